// File: doc/BRIEF.md
# External Bus Byte-Strobe Controller

This block runs external memory cycles for a 16-bit processor core. The data bus on the board can be 8 or 16 bits wide. The core makes a request that carries an address, a byte or word size, a direction and write data. The block turns the request into one or two bus cycles. Each cycle has an address phase, a strobe phase and a recovery phase. When the last cycle is finished, the block returns a one-clock completion pulse and, for reads, the assembled data.

Two configuration bits select the strobe style. The write pin can pulse on every write, or only when the low byte lane is written. The high-byte pin can act as an active-low byte-high enable for the whole cycle, or as a write strobe for the high lane. A slow device can hold the ready input low to stretch the strobe phase. A 2-bit cap limits the number of wait states per cycle, and a cap of zero makes the block ignore ready. The configuration is captured when a request is accepted.

Top module: `bus_strobe_ctrl`

## Requirements
- R1: `bus_rd_n` is low only during the strobe phase of a read cycle. It stays high in write cycles and when idle, and it is never low at the same time as `bus_wr_n`.
- R2: With `cfg_wr_low_only`=0, `bus_wr_n` is low for the whole strobe phase of every write cycle and high at all other times.
- R3: With `cfg_wr_low_only`=1, `bus_wr_n` is low only in the strobe phase of write cycles that use the low lane (`bus_dout[7:0]`). A write to the high lane only leaves it high.
- R4: On a 16-bit bus with `cfg_hi_is_wstrobe`=0, `bus_bhe_n` is low from the address phase through the recovery phase of every cycle that uses the high lane. The lanes are encoded as follows: low lane only is `bus_addr[0]`=0 with `bus_bhe_n`=1; high lane only is `bus_addr[0]`=1 with `bus_bhe_n`=0; both lanes are `bus_addr[0]`=0 with `bus_bhe_n`=0. `bus_addr` is held for the whole cycle.
- R5: On a 16-bit bus with `cfg_hi_is_wstrobe`=1, `bus_bhe_n` is low only in the strobe phase of write cycles that use the high lane (`bus_dout[15:8]`).
- R6: With `cfg_bus16`=0, `bus_bhe_n` stays high and every cycle moves one byte on the low lane. A word request becomes two cycles: first the byte at the given address, then the byte at that address plus one.
- R7: On a 16-bit bus, a word request at an odd address becomes two cycles. The first cycle moves the low data byte on the high lane at the given address. The second moves the high data byte on the low lane at the address plus one. A word at an even address takes one cycle on both lanes.
- R8: If `bus_ready` is high at the end of the first strobe clock, the cycle adds no wait state and lasts exactly three clocks.
- R9: If `bus_ready` is low at the end of a strobe clock, the block adds one wait clock, up to `cfg_wait_cap` wait clocks. The strobe phase ends at the first clock edge where `bus_ready` is high or the cap has been reached.
- R10: When `cfg_wait_cap`=0, `bus_ready` is ignored and every cycle lasts three clocks.
- R11: `done` is a one-clock pulse in the recovery phase of the last cycle of a request. At that time `rdata` holds the read bytes in address order (byte at the address in `rdata[7:0]`), with `rdata[15:8]`=0 for byte reads. `req_ready` is high only while the block is idle.
- R12: During reset, `bus_rd_n`, `bus_wr_n` and `bus_bhe_n` are high, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | 16 | Write data; the byte at the address is in [7:0] |
| req_ready | output | 1 | Block is idle and accepts a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result, valid while `done` is high |
| cfg_bus16 | input | 1 | 1 = 16-bit data bus, 0 = 8-bit data bus |
| cfg_wr_low_only | input | 1 | Write pin pulses only for low-lane writes |
| cfg_hi_is_wstrobe | input | 1 | High-byte pin acts as high-lane write strobe |
| cfg_wait_cap | input | 2 | Maximum wait states per cycle; 0 ignores ready |
| bus_addr | output | AW | Address of the current bus cycle |
| bus_dout | output | 16 | Write data on the bus lanes |
| bus_din | input | 16 | Read data from the bus lanes |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe (all writes or low lane only) |
| bus_bhe_n | output | 1 | Active-low high-byte enable or high-lane write strobe |
| bus_ready | input | 1 | High when the device is ready; low adds wait states |

## Verification
The assertions assume the following about the inputs. `bus_ready` and `bus_din` are steady around each rising edge. The configuration inputs are only read when a request is accepted, so they need to be valid only in that cycle. `req_valid` is considered only while `req_ready` is high. The bench applies every input on the falling clock edge. It presents a request only while the block is idle and drops it after the accepting edge. It drives `bus_ready` from a count of low samples that starts again in each strobe phase. This keeps ready steady at every edge the block samples, and the bench can predict each wait state from that count and the cap.

// File: rtl/bus_strobe_ctrl.sv
module bus_strobe_ctrl #(
  parameter int AW   = 16,
  parameter int CAPW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_word,
  input  logic [AW-1:0]   req_addr,
  input  logic [15:0]     req_wdata,
  output logic            req_ready,
  output logic            done,
  output logic [15:0]     rdata,
  input  logic            cfg_bus16,
  input  logic            cfg_wr_low_only,
  input  logic            cfg_hi_is_wstrobe,
  input  logic [CAPW-1:0] cfg_wait_cap,
  output logic [AW-1:0]   bus_addr,
  output logic [15:0]     bus_dout,
  input  logic [15:0]     bus_din,
  output logic            bus_rd_n,
  output logic            bus_wr_n,
  output logic            bus_bhe_n,
  input  logic            bus_ready
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_STRB, S_WAIT, S_RECV} st_t;

  st_t            st;
  logic [AW-1:0]  addr_q;
  logic [15:0]    wdata_q;
  logic           wr_q, word_q, b16_q, wlo_q, whi_q, sec_q;
  logic [CAPW-1:0] cap_q, wcnt;

  logic two, hi_lane, lo_lane, both, strobe, in_cyc, end_strb;
  logic [7:0] byte_sel;

  assign two      = word_q & (addr_q[0] | ~b16_q);
  assign hi_lane  = b16_q & ~sec_q & (word_q | addr_q[0]);
  assign lo_lane  = sec_q | ~b16_q | ~addr_q[0];
  assign both     = hi_lane & lo_lane;
  assign byte_sel = sec_q ? wdata_q[15:8] : wdata_q[7:0];
  assign strobe   = (st == S_STRB) || (st == S_WAIT);
  assign in_cyc   = (st != S_IDLE);

  assign end_strb = ((st == S_STRB) && ((cap_q == '0) || bus_ready)) ||
                    ((st == S_WAIT) && (bus_ready || (wcnt == cap_q)));

  assign bus_addr  = sec_q ? addr_q + AW'(1) : addr_q;
  assign bus_dout  = both ? wdata_q : {byte_sel, byte_sel};
  assign bus_rd_n  = ~(strobe & ~wr_q);
  assign bus_wr_n  = ~(strobe & wr_q & (~wlo_q | lo_lane));
  assign bus_bhe_n = ~b16_q ? 1'b1 :
                     whi_q  ? ~(strobe & wr_q & hi_lane) : ~(in_cyc & hi_lane);
  assign done      = (st == S_RECV) && (sec_q || ~two);
  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      b16_q   <= 1'b0;
      wlo_q   <= 1'b0;
      whi_q   <= 1'b0;
      cap_q   <= '0;
      sec_q   <= 1'b0;
      wcnt    <= '0;
      rdata   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          word_q  <= req_word;
          b16_q   <= cfg_bus16;
          wlo_q   <= cfg_wr_low_only;
          whi_q   <= cfg_hi_is_wstrobe;
          cap_q   <= cfg_wait_cap;
          sec_q   <= 1'b0;
          st      <= S_ADDR;
        end
        S_ADDR: begin
          wcnt <= '0;
          st   <= S_STRB;
        end
        S_STRB: if (end_strb) st <= S_RECV;
                else begin
                  wcnt <= CAPW'(1);
                  st   <= S_WAIT;
                end
        S_WAIT: if (end_strb) st <= S_RECV;
                else wcnt <= wcnt + CAPW'(1);
        S_RECV: if (two && !sec_q) begin
                  sec_q <= 1'b1;
                  st    <= S_ADDR;
                end else st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (end_strb && !wr_q) begin
        if (both)       rdata <= bus_din;
        else if (sec_q) rdata[15:8] <= bus_din[7:0];
        else            rdata <= {8'h00, hi_lane ? bus_din[15:8] : bus_din[7:0]};
      end
    end
  end

  AST_RD_WR_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !bus_rd_n |-> bus_wr_n);                        // R1
  AST_WR_IN_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) !bus_wr_n |-> (wr_q && strobe));               // R2
  AST_ADDR_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) strobe |-> $stable(bus_addr));                 // R4
  AST_BYTE_BUS_BHE: assert property (@(posedge clk) disable iff (!rst_n) (in_cyc && !b16_q) |-> bus_bhe_n);             // R6
  AST_READY_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n) (st == S_STRB && bus_ready) |=> st == S_RECV);  // R8
  AST_WAIT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) (st == S_WAIT) |-> (wcnt <= cap_q && cap_q != '0)); // R9
  AST_CAP0_IGNORE:  assert property (@(posedge clk) disable iff (!rst_n) (st == S_STRB && cap_q == '0) |=> st == S_RECV); // R10
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                               // R11

endmodule

// File: tb/test_bus_strobe_ctrl.sv
module test_bus_strobe_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_word = 0;
  logic [15:0] req_addr = '0, req_wdata = '0, bus_din = '0;
  logic cfg_bus16 = 0, cfg_wr_low_only = 0, cfg_hi_is_wstrobe = 0, bus_ready = 1;
  logic [1:0] cfg_wait_cap = '0;
  logic req_ready, done, bus_rd_n, bus_wr_n, bus_bhe_n;
  logic [15:0] rdata, bus_addr, bus_dout;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  bus_strobe_ctrl #(.AW(16), .CAPW(2)) i_bus_strobe_ctrl (
    .clk, .rst_n, .req_valid, .req_write, .req_word, .req_addr, .req_wdata,
    .req_ready, .done, .rdata, .cfg_bus16, .cfg_wr_low_only, .cfg_hi_is_wstrobe,
    .cfg_wait_cap, .bus_addr, .bus_dout, .bus_din, .bus_rd_n, .bus_wr_n,
    .bus_bhe_n, .bus_ready);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mem(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic run(bit w, bit word, logic [15:0] a, logic [15:0] d, bit b16,
                     bit wlo, bit whi, logic [1:0] cap, int rlow);
    int nsub, nw;
    logic [15:0] exp_rd;
    string treq;
    req_valid = 1; req_write = w; req_word = word; req_addr = a; req_wdata = d;
    cfg_bus16 = b16; cfg_wr_low_only = wlo; cfg_hi_is_wstrobe = whi; cfg_wait_cap = cap;
    chk("R11", "req_ready idle", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    nsub = (word && (a[0] || !b16)) ? 2 : 1;
    nw   = (cap == 0) ? 0 : ((rlow < int'(cap)) ? rlow : int'(cap));
    treq = (cap == 0) ? "R10" : (rlow == 0) ? "R8" : "R9";
    exp_rd = word ? {mem(a + 16'd1), mem(a)} : {8'h00, mem(a)};
    for (int s = 0; s < nsub; s++) begin
      logic [15:0] sa;
      bit hi, lo;
      logic [7:0] bv;
      sa = (s == 1) ? a + 16'd1 : a;
      hi = b16 && s == 0 && (word || a[0]);
      lo = (s == 1) || !b16 || !a[0];
      bv = (s == 1) ? d[15:8] : d[7:0];
      for (int j = 0; j < nw + 3; j++) begin
        int ph;
        ph = (j == 0) ? 0 : (j == nw + 2) ? 2 : 1;
        bus_ready = (ph == 1) ? ((j - 1) >= rlow) : 1'b1;
        bus_din = b16 ? {mem(sa | 16'd1), mem(sa & 16'hFFFE)} : {8'hEE, mem(sa)};
        chk(nsub == 2 ? (b16 ? "R7" : "R6") : "R4", "bus_addr", 32'(bus_addr), 32'(sa));
        chk("R1", "rd_n", 32'(bus_rd_n), 32'(!(!w && ph == 1)));
        chk(wlo ? "R3" : "R2", "wr_n", 32'(bus_wr_n), 32'(!(w && ph == 1 && (!wlo || lo))));
        chk(!b16 ? "R6" : whi ? "R5" : "R4", "bhe_n", 32'(bus_bhe_n),
            32'(!b16 ? 1'b1 : whi ? !(w && ph == 1 && hi) : !hi));
        chk("R11", "req_ready busy", 32'(req_ready), 0);
        chk(treq, "done timing", 32'(done), 32'(ph == 2 && s == nsub - 1));
        if (w && ph == 1) begin
          if (hi && lo) chk("R7", "dout word", 32'(bus_dout), 32'(d));
          else if (hi)  chk("R7", "dout hi lane", 32'(bus_dout[15:8]), 32'(bv));
          else          chk("R6", "dout lo lane", 32'(bus_dout[7:0]), 32'(bv));
        end
        if (!w && ph == 2 && s == nsub - 1) chk("R11", "rdata", 32'(rdata), 32'(exp_rd));
        @(negedge clk);
      end
    end
    bus_ready = 1;
    chk("R11", "done cleared", 32'(done), 0);
    chk("R1", "rd_n idle", 32'(bus_rd_n), 1);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R11 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R12", "rd_n reset", 32'(bus_rd_n), 1);
    chk("R12", "wr_n reset", 32'(bus_wr_n), 1);
    chk("R12", "bhe_n reset", 32'(bus_bhe_n), 1);
    chk("R12", "done reset", 32'(done), 0);
    chk("R12", "req_ready reset", 32'(req_ready), 1);
    rst_n = 1;
    @(negedge clk);
    run(0, 1, 16'h1234, 16'h0, 1, 0, 0, 2'd0, 0);
    run(1, 1, 16'h2345, 16'hA1B2, 1, 0, 0, 2'd3, 0);
    run(0, 1, 16'h2345, 16'h0, 1, 0, 0, 2'd2, 1);
    run(1, 0, 16'h0101, 16'h00C7, 1, 1, 0, 2'd1, 0);
    run(1, 0, 16'h0100, 16'h00C7, 1, 0, 1, 2'd1, 0);
    run(0, 0, 16'h0333, 16'h0, 1, 0, 1, 2'd3, 2);
    run(1, 1, 16'h4000, 16'h5A6B, 0, 1, 1, 2'd0, 3);
    run(0, 1, 16'h4001, 16'h0, 0, 0, 0, 2'd3, 5);
    run(1, 1, 16'h7FFE, 16'hF00D, 1, 0, 1, 2'd3, 3);
    run(0, 0, 16'hFFFF, 16'h0, 1, 0, 0, 2'd2, 7);
    for (int k = 0; k < 200; k++) begin
      logic [31:0] r;
      r = $urandom;
      run(r[0], r[1], 16'($urandom), 16'($urandom), r[2], r[3], r[4], r[6:5], int'(r[9:7] % 5));
    end
    summary();
    $finish;
  end
endmodule